// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block sits in front of a two-port memory and watches both ports on every clock cycle. A collision is when both ports are selected and present the same address. On a collision the block grants the location to one port and drives an active-low busy flag toward the other port. The losing port's write is blocked for as long as its busy flag is low. The winner is the port whose request arrived first. A request arrives in the cycle its select rises or its address changes while it is selected. A port that waits keeps its request applied, and its write goes through once the busy flag is released.

When several of these blocks are placed side by side to widen the data bus, they must not each arbitrate on their own. If they did, one bank could stall the left port while another stalled the right, and both processors would wait for ever. For that case a mode input turns an instance into a follower. Its own arbiter is switched off and it takes the busy flags from the leading instance through dedicated inputs. It lets a write through only after the incoming flag has been released for at least one full cycle.

Top module: `dp_collision_arbiter`

## Requirements
- R1: In leader mode (`follower_mode`=0), when both selects are high and both addresses are equal, exactly one of `l_busy_n` and `r_busy_n` is low in that same cycle. With no collision and no held grant, both are high.
- R2: `l_wr_go` / `r_wr_go` equal the port's write request ANDed with its select. They are forced low whenever that port's busy flag is low.
- R3: If the addresses are already equal and one select rose in an earlier cycle than the other, the port that was selected earlier wins. The later port sees busy low.
- R4: If both ports are already selected and one port moves onto the address the other already holds, the port that was already there wins.
- R5: If both requests arrive in the same cycle, the left port wins and `r_busy_n` goes low.
- R6: A grant lasts while the winner keeps its select high and its address unchanged. In the cycle the winner drops its select or changes its address, the loser's busy flag is still low. It is high from the next cycle, and the loser's held write is then issued.
- R7: In follower mode, `l_busy_n` / `r_busy_n` copy `l_busy_in_n` / `r_busy_in_n`, and no internal arbitration takes place, even on an address collision.
- R8: In follower mode, a port's write is issued only if its busy input is high in the current cycle and was also high in the previous cycle.
- R9: While `rst` is high, both busy outputs are high and both write outputs are low, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| follower_mode | input | 1 | 1: take busy flags from inputs; 0: arbitrate internally |
| l_sel | input | 1 | Left port select, active high |
| l_wr | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port address |
| r_sel | input | 1 | Right port select, active high |
| r_wr | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | Left busy from the leading instance (follower mode) |
| r_busy_in_n | input | 1 | Right busy from the leading instance (follower mode) |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_go | output | 1 | Gated write strobe to the memory, left |
| r_wr_go | output | 1 | Gated write strobe to the memory, right |

## Verification
The assertions check, on every cycle, the properties that do not depend on history. A collision in leader mode yields exactly one busy flag. A port with busy low never issues a write. A follower never writes straight after its busy input was low. A winner that has left releases the loser one cycle later, and reset holds the outputs idle. Which port wins depends on the order in which requests arrived, so only the bench scenarios can show the winner choice. These scenarios cover a sweep of all address pairs on a small address width, select-order and address-order contests, and the deferred write after release.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    // Which port currently owns a contested location.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_e;

    // Per-port view used by the arbiter core.
    typedef struct packed {
        logic sel;
        logic fresh;   // request arrived this cycle
    } port_stat_t;

    // The port whose request is older wins; simultaneous arrival goes left.
    function automatic owner_e pick_winner(input port_stat_t l, input port_stat_t r);
        if (l.fresh && !r.fresh) begin
            return OWN_RIGHT;
        end
        return OWN_LEFT;
    endfunction

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output dpa_pkg::port_stat_t stat
);
    logic              sel_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            sel_q  <= sel;
            addr_q <= addr;
        end
    end

    always_comb begin
        stat.sel   = sel;
        stat.fresh = sel && (!sel_q || (addr != addr_q));
    end
endmodule

// File: rtl/dpa_arb_core.sv
module dpa_arb_core #(
    parameter int ADDR_W = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  dpa_pkg::port_stat_t l_stat,
    input  dpa_pkg::port_stat_t r_stat,
    input  logic [ADDR_W-1:0]   l_addr,
    input  logic [ADDR_W-1:0]   r_addr,
    output dpa_pkg::owner_e     owner
);
    import dpa_pkg::*;

    owner_e            grant_q;
    logic [ADDR_W-1:0] held_addr_q;
    logic              collide;
    logic              winner_done;
    owner_e            fresh_pick;

    always_comb begin
        collide     = l_stat.sel && r_stat.sel && (l_addr == r_addr);
        fresh_pick  = pick_winner(l_stat, r_stat);
        winner_done = 1'b0;
        case (grant_q)
            OWN_LEFT:  winner_done = !l_stat.sel || (l_addr != held_addr_q);
            OWN_RIGHT: winner_done = !r_stat.sel || (r_addr != held_addr_q);
            default:   winner_done = 1'b0;
        endcase
        if (!enable) begin
            owner = OWN_NONE;
        end else if (grant_q != OWN_NONE) begin
            owner = grant_q;
        end else if (collide) begin
            owner = fresh_pick;
        end else begin
            owner = OWN_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            grant_q     <= OWN_NONE;
            held_addr_q <= '0;
        end else if (grant_q == OWN_NONE) begin
            if (collide) begin
                grant_q     <= fresh_pick;
                held_addr_q <= l_addr;
            end
        end else if (winner_done) begin
            grant_q <= OWN_NONE;
        end
    end
endmodule

// File: rtl/dpa_wr_gate.sv
module dpa_wr_gate (
    input  logic clk,
    input  logic rst,
    input  logic follower,
    input  logic sel,
    input  logic wr,
    input  logic busy_int_n,
    input  logic busy_ext_n,
    output logic busy_n,
    output logic wr_go
);
    logic ext_q;   // external busy was released in the previous cycle

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= busy_ext_n;
        end
    end

    always_comb begin
        if (rst) begin
            busy_n = 1'b1;
            wr_go  = 1'b0;
        end else if (follower) begin
            busy_n = busy_ext_n;
            wr_go  = sel && wr && busy_ext_n && ext_q;
        end else begin
            busy_n = busy_int_n;
            wr_go  = sel && wr && busy_int_n;
        end
    end
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              follower_mode,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_go,
    output logic              r_wr_go
);
    import dpa_pkg::*;

    localparam int NPORT = 2;

    logic [NPORT-1:0]  sel_v;
    logic [NPORT-1:0]  wr_v;
    logic [NPORT-1:0]  ext_v;
    logic [NPORT-1:0]  int_v;
    logic [NPORT-1:0]  busy_v;
    logic [NPORT-1:0]  go_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    port_stat_t        stat_v [NPORT];
    owner_e            owner;

    assign sel_v     = {r_sel, l_sel};
    assign wr_v      = {r_wr, l_wr};
    assign ext_v     = {r_busy_in_n, l_busy_in_n};
    assign addr_v[0] = l_addr;
    assign addr_v[1] = r_addr;

    // A port is held off when the other port owns the location.
    assign int_v[0] = (owner != OWN_RIGHT);
    assign int_v[1] = (owner != OWN_LEFT);

    dpa_arb_core #(.ADDR_W(ADDR_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .enable (!follower_mode),
        .l_stat (stat_v[0]),
        .r_stat (stat_v[1]),
        .l_addr (l_addr),
        .r_addr (r_addr),
        .owner  (owner)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk  (clk),
            .rst  (rst),
            .sel  (sel_v[p]),
            .addr (addr_v[p]),
            .stat (stat_v[p])
        );
        dpa_wr_gate u_gate (
            .clk        (clk),
            .rst        (rst),
            .follower   (follower_mode),
            .sel        (sel_v[p]),
            .wr         (wr_v[p]),
            .busy_int_n (int_v[p]),
            .busy_ext_n (ext_v[p]),
            .busy_n     (busy_v[p]),
            .wr_go      (go_v[p])
        );
    end

    assign l_busy_n = busy_v[0];
    assign r_busy_n = busy_v[1];
    assign l_wr_go  = go_v[0];
    assign r_wr_go  = go_v[1];
endmodule

// File: rtl/dpa_checks.sv
module dpa_checks #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              follower_mode,
    input logic              l_sel,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_sel,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_go,
    input logic              r_wr_go
);
    p_one_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (!follower_mode && l_sel && r_sel && (l_addr == r_addr))
        |-> ($countones({l_busy_n, r_busy_n}) == 1));

    p_l_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        !l_busy_n |-> !l_wr_go);

    p_r_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        !r_busy_n |-> !r_wr_go);

    p_l_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!follower_mode && !l_busy_n && !r_sel) |=> (follower_mode || l_busy_n));

    p_r_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!follower_mode && !r_busy_n && !l_sel) |=> (follower_mode || r_busy_n));

    p_l_settle_r8: assert property (@(posedge clk) disable iff (rst)
        (follower_mode && !$past(l_busy_in_n)) |-> !l_wr_go);

    p_r_settle_r8: assert property (@(posedge clk) disable iff (rst)
        (follower_mode && !$past(r_busy_in_n)) |-> !r_wr_go);

    p_reset_idle_r9: assert property (@(posedge clk)
        rst |-> (l_busy_n && r_busy_n && !l_wr_go && !r_wr_go));
endmodule

bind dp_collision_arbiter dpa_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk           (clk),
    .rst           (rst),
    .follower_mode (follower_mode),
    .l_sel         (l_sel),
    .l_addr        (l_addr),
    .r_sel         (r_sel),
    .r_addr        (r_addr),
    .l_busy_in_n   (l_busy_in_n),
    .r_busy_in_n   (r_busy_in_n),
    .l_busy_n      (l_busy_n),
    .r_busy_n      (r_busy_n),
    .l_wr_go       (l_wr_go),
    .r_wr_go       (r_wr_go)
);

// File: tb/tb_dp_collision_arbiter.sv
module tb_dp_collision_arbiter;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          follower_mode = 1'b0;
    logic          l_sel = 1'b0, r_sel = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_n, r_busy_n, l_wr_go, r_wr_go;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dp_collision_arbiter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .follower_mode(follower_mode),
        .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr),
        .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Compare {l_busy_n, r_busy_n, l_wr_go, r_wr_go}
    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        #0.5;
        act = {l_busy_n, r_busy_n, l_wr_go, r_wr_go};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {lb_n,rb_n,lgo,rgo} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        l_sel = 0; r_sel = 0; l_wr = 0; r_wr = 0;
        tick();
    endtask

    initial begin
        // R9: reset holds outputs idle even with a colliding write request
        l_sel = 1; r_sel = 1; l_wr = 1; r_wr = 1; l_addr = 3; r_addr = 3;
        tick();
        check("R9", 4'b1100);
        tick();
        check("R9", 4'b1100);
        rst = 0;
        idle();
        check("R1", 4'b1100);

        // R1/R5/R2: sweep all address pairs, both arriving in the same cycle
        for (int a = 0; a < (1 << AW); a++) begin
            for (int b = 0; b < (1 << AW); b++) begin
                idle();
                l_sel = 1; r_sel = 1; l_wr = 1; r_wr = 1;
                l_addr = a[AW-1:0]; r_addr = b[AW-1:0];
                check(a == b ? "R5" : "R1", (a == b) ? 4'b1010 : 4'b1111);
                tick();
            end
        end
        idle();

        // R3: right selected first on an equal address, left arrives later
        l_addr = 5; r_addr = 5;
        r_sel = 1; r_wr = 1;
        tick();
        l_sel = 1; l_wr = 1;
        check("R3", 4'b0101);
        tick();
        check("R3", 4'b0101);
        // R6: winner drops select; loser still busy this cycle, released next
        r_sel = 0; r_wr = 0;
        check("R6", 4'b0100);
        tick();
        check("R6", 4'b1110);
        idle();

        // R3 mirrored: left first
        l_sel = 1; l_addr = 2; r_addr = 2;
        tick();
        r_sel = 1; r_wr = 1;
        check("R3", 4'b1000);
        idle();

        // R4: both selected on different addresses, left moves onto right's
        l_sel = 1; r_sel = 1; l_wr = 1; r_wr = 1; l_addr = 2; r_addr = 4;
        tick();
        check("R1", 4'b1111);
        l_addr = 4;
        check("R4", 4'b0101);
        tick();
        // R6: winner changes address; release one cycle later
        r_addr = 6;
        check("R6", 4'b0101);
        tick();
        check("R6", 4'b1111);
        idle();

        // R4 mirrored: right moves onto left's address
        l_sel = 1; r_sel = 1; l_wr = 1; r_wr = 1; l_addr = 1; r_addr = 7;
        tick();
        r_addr = 1;
        check("R4", 4'b1010);
        tick();
        check("R4", 4'b1010);
        idle();

        // R2: write without select is not issued
        l_wr = 1; r_wr = 1;
        check("R2", 4'b1100);
        idle();

        // Follower mode
        follower_mode = 1;
        l_busy_in_n = 1; r_busy_in_n = 1;
        tick();
        tick();
        // R7: collision not arbitrated, inputs high and settled
        l_sel = 1; r_sel = 1; l_wr = 1; r_wr = 1; l_addr = 3; r_addr = 3;
        check("R7", 4'b1111);
        l_busy_in_n = 0;
        check("R7", 4'b0101);
        tick();
        check("R7", 4'b0101);
        // R8: release is not used in the same cycle
        l_busy_in_n = 1;
        check("R8", 4'b1101);
        tick();
        check("R8", 4'b1111);
        r_busy_in_n = 0;
        check("R7", 4'b1010);
        tick();
        r_busy_in_n = 1;
        check("R8", 4'b1110);
        tick();
        check("R8", 4'b1111);
        idle();
        follower_mode = 0;
        idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule